// File: doc/BRIEF.md
# Stop-and-Wait Retransmitting Frame Sender

This block is the transmit half of a stop-and-wait link with automatic repeat. It takes one frame descriptor at a time from an upstream source through a request/grant handshake and stores it. It marks the frame with a one-bit sequence tag and raises a one-cycle send strobe. It then holds that frame until the peer returns an acknowledgement that names the tag it expects next.

While it waits, a cycle-count timer runs. When the timer runs out with no valid acknowledgement, the same frame is sent again with the same tag, so a receiver that already holds the frame can spot the copy and discard it. An acknowledgement whose tag is not the expected next value is ignored, and the timer keeps running. After a set number of timeouts in a row, the sender gives up and raises an error. It stays halted until reset.

Top module: `arq_sender`

## Requirements
- R1: After reset, `tx_send`, `req_grant` (with `req_valid` low) and `link_fail` are 0, and the first frame sent carries tag 0.
- R2: `req_grant` is high only in a cycle where the sender is idle and `req_valid` is high. While a frame is outstanding, `req_valid` gets no grant.
- R3: One cycle after a grant, `tx_send` pulses for exactly one cycle. In that cycle `tx_desc` equals the granted descriptor and `tx_tag` equals the current tag.
- R4: An acknowledgement with `ack_valid`=1 and `ack_tag` equal to the inverse of the outstanding tag completes the frame. The sender returns to idle, and the next frame carries the inverted tag.
- R5: An acknowledgement whose `ack_tag` equals the outstanding tag is ignored. The retransmission still happens TIMEOUT+1 cycles after the previous strobe.
- R6: With no valid acknowledgement, the frame is resent TIMEOUT+1 cycles after the previous strobe, with the same tag and descriptor.
- R7: A valid acknowledgement in the same cycle as the timer expiry wins: no retransmission follows.
- R8: After MAX_RETRY consecutive timeouts on one frame, `link_fail` goes to 1 and stays there until reset. While it is set, no send strobe and no grant occur, and acknowledgements are ignored.
- R9: A valid acknowledgement clears the timeout count, so timeouts spread over different frames do not add up to an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Upstream has a frame descriptor ready |
| req_desc | input | DESC_W | Frame descriptor offered upstream |
| req_grant | output | 1 | Descriptor taken this cycle |
| tx_send | output | 1 | One-cycle frame transmit strobe |
| tx_tag | output | 1 | Sequence tag of the frame being sent |
| tx_desc | output | DESC_W | Descriptor of the frame being sent |
| ack_valid | input | 1 | Acknowledgement present this cycle |
| ack_tag | input | 1 | Tag the peer expects next |
| link_fail | output | 1 | Retry limit reached; sticky until reset |

## Verification
The embedded properties check the following on every cycle:
- The send strobe lasts a single cycle and always follows a grant by one cycle.
- The timer and retry counters stay in range.
- The failure flag is sticky and silences the handshake.
- An acknowledgement that arrives at expiry sends the sender to idle.

Only the bench scenarios can show the rest:
- The exact retransmission spacing and the tag alternation across frames.
- That a mismatched acknowledgement leaves the timer untouched.
- That a lost acknowledgement yields a duplicate that the receiver model discards.
- That the retry count resets between frames.

// File: rtl/arq_pkg.sv
package arq_pkg;

    localparam int DESC_W_DEF    = 8;
    localparam int TIMEOUT_DEF   = 12;
    localparam int MAX_RETRY_DEF = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2,
        ST_HALT = 2'd3
    } arq_state_e;

    // Events seen while a frame is outstanding
    typedef struct packed {
        logic good;     // acknowledgement names the next tag
        logic expired;  // wait timer ran out
    } wait_ev_t;

    function automatic logic tag_next(input logic cur);
        return ~cur;
    endfunction

    function automatic logic ack_matches(input logic ack, input logic cur);
        return ack == tag_next(cur);
    endfunction

endpackage

// File: rtl/arq_timer.sv
module arq_timer #(
    parameter int TIMEOUT = arq_pkg::TIMEOUT_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST); // R6

    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/arq_retry.sv
module arq_retry #(
    parameter int MAX_RETRY = arq_pkg::MAX_RETRY_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic bump,
    output logic last
);
    localparam int RW = $clog2(MAX_RETRY + 1);
    localparam logic [RW-1:0] LIMIT = RW'(MAX_RETRY - 1);

    logic [RW-1:0] cnt_q;

    assign last = (cnt_q == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (bump) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_RETRY_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT); // R8

    AST_RETRY_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/arq_sender.sv
module arq_sender #(
    parameter int DESC_W    = arq_pkg::DESC_W_DEF,
    parameter int TIMEOUT   = arq_pkg::TIMEOUT_DEF,
    parameter int MAX_RETRY = arq_pkg::MAX_RETRY_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [DESC_W-1:0] req_desc,
    output logic              req_grant,
    output logic              tx_send,
    output logic              tx_tag,
    output logic [DESC_W-1:0] tx_desc,
    input  logic              ack_valid,
    input  logic              ack_tag,
    output logic              link_fail
);
    import arq_pkg::*;

    arq_state_e        state_q, state_d;
    logic              tag_q;
    logic [DESC_W-1:0] desc_q;
    wait_ev_t          ev;
    logic              tmr_expired;
    logic              retry_last;

    assign ev.good    = (state_q == ST_WAIT) && ack_valid && ack_matches(ack_tag, tag_q);
    assign ev.expired = tmr_expired;

    arq_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (state_q == ST_SEND),
        .run     (state_q == ST_WAIT),
        .expired (tmr_expired)
    );

    arq_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk   (clk),
        .rst   (rst),
        .clear (ev.good),
        .bump  (ev.expired && !ev.good && !retry_last),
        .last  (retry_last)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_SEND;
            ST_SEND: state_d = ST_WAIT;
            ST_WAIT: begin
                if (ev.good)             state_d = ST_IDLE;
                else if (ev.expired)     state_d = retry_last ? ST_HALT : ST_SEND;
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tag_q   <= 1'b0;
            desc_q  <= '0;
        end else begin
            state_q <= state_d;
            if (ev.good)   tag_q  <= tag_next(tag_q);
            if (req_grant) desc_q <= req_desc;
        end
    end

    assign req_grant = (state_q == ST_IDLE) && req_valid;
    assign tx_send   = (state_q == ST_SEND);
    assign tx_tag    = tag_q;
    assign tx_desc   = desc_q;
    assign link_fail = (state_q == ST_HALT);

    AST_SEND_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        tx_send |=> !tx_send); // R3

    AST_GRANT_THEN_SEND: assert property (@(posedge clk) disable iff (rst)
        req_grant |=> tx_send); // R3

    AST_TAG_HELD: assert property (@(posedge clk) disable iff (rst)
        tx_send |=> $stable(tx_tag)); // R6

    AST_ACK_BEATS_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        (ev.good && ev.expired) |=> (state_q == ST_IDLE && !tx_send)); // R7

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        link_fail |=> link_fail); // R8

    AST_FAIL_SILENT: assert property (@(posedge clk) disable iff (rst)
        link_fail |-> (!tx_send && !req_grant)); // R8

endmodule

// File: tb/arq_sender_bench.sv
module arq_sender_bench;
    localparam int DW = 8;
    localparam int TO = 6;
    localparam int MR = 3;

    // vector: {mode[1:0], descriptor[7:0]}
    // mode 0 clean, 1 frame lost, 2 stale ack then good, 3 ack lost
    localparam int NV = 7;
    localparam logic [9:0] VEC [NV] = '{
        {2'd0, 8'h11}, {2'd1, 8'h22}, {2'd2, 8'h33}, {2'd3, 8'h44},
        {2'd0, 8'h55}, {2'd3, 8'h66}, {2'd1, 8'h77}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [DW-1:0] req_desc = '0;
    logic req_grant, tx_send, tx_tag, link_fail;
    logic [DW-1:0] tx_desc;
    logic ack_valid = 1'b0;
    logic ack_tag = 1'b0;

    int total = 0;
    int failed = 0;
    bit rx_expect = 1'b0;
    int rx_count = 0;
    int dup_count = 0;
    logic [DW-1:0] rx_last = '0;

    always #2 clk = ~clk;

    arq_sender #(.DESC_W(DW), .TIMEOUT(TO), .MAX_RETRY(MR)) u_arq_sender (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_desc(req_desc),
        .req_grant(req_grant), .tx_send(tx_send), .tx_tag(tx_tag),
        .tx_desc(tx_desc), .ack_valid(ack_valid), .ack_tag(ack_tag),
        .link_fail(link_fail)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic rx_model();
        if (tx_tag == rx_expect) begin
            rx_count++;
            rx_last = tx_desc;
            rx_expect = ~rx_expect;
        end else begin
            dup_count++;
        end
    endtask

    task automatic gap_to_send(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!tx_send && n < 100);
    endtask

    task automatic send_ack(input logic t);
        ack_valid = 1'b1;
        ack_tag   = t;
        step();
        ack_valid = 1'b0;
    endtask

    // offer a frame at an idle negedge; returns at the strobe negedge
    task automatic offer(input logic [DW-1:0] d, input logic exp_tag);
        req_valid = 1'b1;
        req_desc  = d;
        #1;
        chk("R2 grant when idle", int'(req_grant), 1);
        step();
        req_valid = 1'b0;
        chk("R3 strobe after grant", int'(tx_send), 1);
        chk("R3 descriptor", int'(tx_desc), int'(d));
        chk("R4 tag alternation", int'(tx_tag), int'(exp_tag));
    endtask

    initial begin
        int n;
        logic exp_tag;
        int dup0;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1 no strobe", int'(tx_send), 0);
        chk("R1 no grant", int'(req_grant), 0);
        chk("R1 no fail", int'(link_fail), 0);

        exp_tag = 1'b0;
        for (int i = 0; i < NV; i++) begin
            logic [1:0] mode;
            logic [DW-1:0] d;
            mode = VEC[i][9:8];
            d    = VEC[i][7:0];
            offer(d, exp_tag);
            case (mode)
                2'd0: begin
                    rx_model();
                    step(); step();
                    send_ack(rx_expect);
                end
                2'd1: begin
                    gap_to_send(n);
                    chk("R6 resend spacing", n, TO + 1);
                    chk("R6 resend tag", int'(tx_tag), int'(exp_tag));
                    chk("R6 resend descriptor", int'(tx_desc), int'(d));
                    rx_model();
                    step();
                    send_ack(rx_expect);
                end
                2'd2: begin
                    rx_model();
                    step();
                    send_ack(~rx_expect);
                    gap_to_send(n);
                    chk("R5 stale ack ignored", n, TO + 1 - 2);
                    rx_model();
                    step();
                    send_ack(rx_expect);
                end
                default: begin
                    rx_model();
                    dup0 = dup_count;
                    gap_to_send(n);
                    chk("R6 resend after lost ack", n, TO + 1);
                    rx_model();
                    chk("R6 duplicate discarded", dup_count, dup0 + 1);
                    step();
                    send_ack(rx_expect);
                end
            endcase
            chk("R4 idle after ack", int'(tx_send), 0);
            chk("R4 receiver holds frame", int'(rx_last), int'(d));
            exp_tag = ~exp_tag;
        end
        chk("R4 frames delivered", rx_count, NV);

        // R2: no grant while outstanding; R7: ack at expiry wins
        req_valid = 1'b1;
        req_desc  = 8'hA5;
        #1;
        chk("R2 grant", int'(req_grant), 1);
        step();
        rx_model();
        for (int k = 0; k < TO; k++) begin
            #1;
            chk("R2 no grant while waiting", int'(req_grant), 0);
            step();
        end
        req_valid = 1'b0;
        send_ack(rx_expect);
        chk("R7 ack at expiry beats resend", int'(tx_send), 0);
        exp_tag = ~exp_tag;

        // R9: timeouts across two frames do not accumulate
        for (int f = 0; f < 2; f++) begin
            offer(8'hC0 + 8'(f), exp_tag);
            gap_to_send(n);
            gap_to_send(n);
            rx_model();
            step();
            send_ack(rx_expect);
            exp_tag = ~exp_tag;
        end
        chk("R9 no fail after acked retries", int'(link_fail), 0);

        // R8: retry limit
        offer(8'hEE, exp_tag);
        gap_to_send(n);
        gap_to_send(n);
        repeat (TO + 1) step();
        chk("R8 fail raised", int'(link_fail), 1);
        chk("R8 no strobe in fail", int'(tx_send), 0);
        req_valid = 1'b1;
        send_ack(~exp_tag);
        n = 0;
        for (int k = 0; k < 3 * TO; k++) begin
            #1;
            if (tx_send || req_grant) n++;
            step();
        end
        chk("R8 silent while failed", n, 0);
        chk("R8 fail sticky", int'(link_fail), 1);
        req_valid = 1'b0;

        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        step();
        chk("R1 fail cleared by reset", int'(link_fail), 0);
        offer(8'h5A, 1'b0);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failed++;
        total++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule